// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block serialises bytes onto an asynchronous line that idles high. Software or a neighbouring block writes a word into a single holding slot. When transmission is enabled, the word moves into a frame shifter and goes out in this order: a low start bit, the data bits with the least significant first, an optional extra bit, and one or two high stop bits. Every bit lasts a fixed number of baud ticks. The baud ticks come from outside the block.

Two framing modes exist. In plain mode the extra bit is an optional parity bit (odd or even), and the data can be 7 or 8 bits wide. In multiprocessor mode the extra bit is always present and carries an address/data marker. In that mode parity is suppressed and the data is always the full width, whatever the control inputs request.

The configuration is captured at the moment a word leaves the holding slot. A word written while a frame is going out waits in the slot. It starts on the bit period that directly follows the current stop bits. Clearing the enable never cuts a frame short: the frame in flight and any word already waiting are both sent, and only then does the line stay idle.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, line_out is 1, hold_empty is 1 and tx_busy is 0. line_out stays 1 whenever no frame is being sent.
- R2: With cfg_mp_mode=0, cfg_wide_data=1, cfg_parity_on=0 and cfg_two_stop=0, a frame is 10 bits long: bit 0 is 0 (start), bits 1..8 are hold_data[0..7], and bit 9 is 1 (stop). Each bit lasts TICKS_PER_BIT (16) baud ticks.
- R3: In plain mode with cfg_wide_data=0, only hold_data[6:0] is sent as 7 data bits, and hold_data[7] is ignored.
- R4: In plain mode with cfg_parity_on=1, one parity bit follows the data bits. With cfg_parity_odd=0 it makes the number of ones in the data plus parity even. With cfg_parity_odd=1 it makes that number odd.
- R5: cfg_two_stop=1 sends two high stop bits, and cfg_two_stop=0 sends one.
- R6: With cfg_mp_mode=1, cfg_parity_on and cfg_wide_data are ignored. Eight data bits are always sent, followed by one bit equal to cfg_addr_mark, then the stop bits.
- R7: A hold_wr pulse while hold_empty=1 stores hold_data, and hold_empty drops to 0. A hold_wr pulse while hold_empty=0 is discarded and never transmitted.
- R8: A word that is waiting when the last stop bit of a frame ends begins its start bit in the very next bit period, with no idle gap.
- R9: While tx_enable=0 and no frame is in flight, a waiting word is held and the line stays idle. Once tx_enable=1, the word starts.
- R10: If tx_enable is cleared during a frame, that frame and any word already waiting are still sent completely, after which the line idles.
- R11: tx_busy is 1 for the whole duration of a frame, and it returns to 0 once the last stop bit ends with nothing waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle baud tick pulse |
| tx_enable | input | 1 | Allows a waiting word to start a frame |
| cfg_mp_mode | input | 1 | 0 plain asynchronous, 1 multiprocessor |
| cfg_parity_on | input | 1 | Append parity bit (plain mode only) |
| cfg_parity_odd | input | 1 | 1 odd parity, 0 even parity |
| cfg_two_stop | input | 1 | 1 two stop bits, 0 one stop bit |
| cfg_wide_data | input | 1 | 1 eight data bits, 0 seven (plain mode only) |
| cfg_addr_mark | input | 1 | Multiprocessor marker bit: 1 address, 0 data |
| hold_wr | input | 1 | Write strobe for the holding slot |
| hold_data | input | DATA_W | Word to transmit |
| line_out | output | 1 | Serial output, idles high |
| hold_empty | output | 1 | Holding slot is free |
| tx_busy | output | 1 | A frame is being sent |

## Verification
Assertions check several properties on every cycle. The line is high whenever no frame is in flight. A new frame always opens with a low level. A full holding slot keeps its word until a frame takes it. The bit timer moves only on baud ticks. With the enable low, the idle state persists, and with the enable high, a waiting word starts at once. Other behaviours can only be shown by the bench scenarios, which decode whole frames at mid-bit points and compare them with frames computed independently: the bit order and frame length for each combination of width, parity, stop length and marker; the dropping of a second write; gapless chaining; and the drain-then-stop behaviour after the enable falls.

// File: rtl/utx_pkg.sv
package utx_pkg;

   // Effective framing options for one frame, after mode rules are applied
   typedef struct packed {
      logic mp_mode;
      logic par_en;
      logic par_odd;
      logic stop2;
      logic len_full;
      logic addr_mark;
   } utx_cfg_t;

endpackage

// File: rtl/utx_cfg_resolve.sv
module utx_cfg_resolve #(
   parameter bit MP_ENABLE = 1'b1
) (
   input  logic              mp_mode,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              stop2,
   input  logic              len_full,
   input  logic              addr_mark,
   output utx_pkg::utx_cfg_t eff
);

   generate
      if (MP_ENABLE) begin : g_mp
         // multiprocessor frames carry the marker instead of parity, full width
         always_comb begin
            eff.mp_mode   = mp_mode;
            eff.par_en    = par_en & ~mp_mode;
            eff.par_odd   = par_odd;
            eff.stop2     = stop2;
            eff.len_full  = len_full | mp_mode;
            eff.addr_mark = addr_mark & mp_mode;
         end
      end else begin : g_plain
         logic unused_mp;
         assign unused_mp = mp_mode ^ addr_mark;
         always_comb begin
            eff.mp_mode   = 1'b0;
            eff.par_en    = par_en;
            eff.par_odd   = par_odd;
            eff.stop2     = stop2;
            eff.len_full  = len_full;
            eff.addr_mark = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/utx_frame_build.sv
module utx_frame_build #(
   parameter int DATA_W  = 8,
   parameter int FRAME_W = DATA_W + 4,
   parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
   input  logic [DATA_W-1:0]  data,
   input  utx_pkg::utx_cfg_t  cfg,
   output logic [FRAME_W-1:0] frame,
   output logic [CNT_W-1:0]   nbits
);

   localparam int SHORT_W = DATA_W - 1;

   logic [DATA_W-1:0] active;
   logic              par_bit;
   int                dlen;
   int                pos;

   always_comb begin
      dlen    = cfg.len_full ? DATA_W : SHORT_W;
      active  = cfg.len_full ? data : {1'b0, data[SHORT_W-1:0]};
      par_bit = (^active) ^ cfg.par_odd;
      frame   = '1;
      frame[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
         if (i < dlen) frame[1 + i] = data[i];
      end
      pos = 1 + dlen;
      if (cfg.mp_mode) begin
         frame[pos] = cfg.addr_mark;
         pos = pos + 1;
      end else if (cfg.par_en) begin
         frame[pos] = par_bit;
         pos = pos + 1;
      end
      nbits = CNT_W'(pos + 1 + int'(cfg.stop2));
   end

endmodule

// File: rtl/utx_hold_buf.sv
module utx_hold_buf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic              full,
   output logic [DATA_W-1:0] data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         data <= '0;
      end else if (take) begin
         full <= 1'b0;
      end else if (wr && !full) begin
         full <= 1'b1;
         data <= wr_data;
      end
   end

   AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !take) |=> (full && $stable(data))); // R7

endmodule

// File: rtl/utx_bit_timer.sv
module utx_bit_timer #(
   parameter int TICKS_PER_BIT = 16,
   parameter int TW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   input  logic baud_tick,
   output logic bit_end
);

   localparam logic [TW-1:0] LAST = TW'(TICKS_PER_BIT - 1);

   logic [TW-1:0] cnt;

   initial assert (TICKS_PER_BIT >= 2) else $fatal(1, "TICKS_PER_BIT must be at least 2");

   assign bit_end = run && baud_tick && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (restart)          cnt <= '0;
      else if (run && baud_tick) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
   end

   AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!baud_tick && !restart) |=> $stable(cnt)); // R2

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter #(
   parameter int FRAME_W = 12,
   parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame,
   input  logic [CNT_W-1:0]   nbits,
   input  logic               bit_end,
   output logic               txd,
   output logic               busy,
   output logic               last_end
);

   logic [FRAME_W-1:0] shreg;
   logic [CNT_W-1:0]   left;

   assign txd      = shreg[0];
   assign last_end = busy && bit_end && (left == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '1;
         left  <= '0;
         busy  <= 1'b0;
      end else if (load) begin
         shreg <= frame;
         left  <= nbits;
         busy  <= 1'b1;
      end else if (busy && bit_end) begin
         shreg <= {1'b1, shreg[FRAME_W-1:1]};
         left  <= left - 1'b1;
         if (left == CNT_W'(1)) busy <= 1'b0;
      end
   end

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
   parameter int DATA_W        = 8,
   parameter int TICKS_PER_BIT = 16,
   parameter bit MP_ENABLE     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              tx_enable,
   input  logic              cfg_mp_mode,
   input  logic              cfg_parity_on,
   input  logic              cfg_parity_odd,
   input  logic              cfg_two_stop,
   input  logic              cfg_wide_data,
   input  logic              cfg_addr_mark,
   input  logic              hold_wr,
   input  logic [DATA_W-1:0] hold_data,
   output logic              line_out,
   output logic              hold_empty,
   output logic              tx_busy
);

   localparam int FRAME_W = DATA_W + 4;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   initial assert (DATA_W >= 5 && DATA_W <= 9) else $fatal(1, "DATA_W out of range");

   utx_pkg::utx_cfg_t  eff;
   logic [DATA_W-1:0]  buf_data;
   logic               buf_full;
   logic [FRAME_W-1:0] frame;
   logic [CNT_W-1:0]   nbits;
   logic               take;
   logic               bit_end;
   logic               busy;
   logic               last_end;
   logic               txd;

   utx_cfg_resolve #(.MP_ENABLE(MP_ENABLE)) u_resolve (
      .mp_mode  (cfg_mp_mode),
      .par_en   (cfg_parity_on),
      .par_odd  (cfg_parity_odd),
      .stop2    (cfg_two_stop),
      .len_full (cfg_wide_data),
      .addr_mark(cfg_addr_mark),
      .eff      (eff)
   );

   utx_hold_buf #(.DATA_W(DATA_W)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (hold_wr),
      .wr_data(hold_data),
      .take   (take),
      .full   (buf_full),
      .data   (buf_data)
   );

   utx_frame_build #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_build (
      .data (buf_data),
      .cfg  (eff),
      .frame(frame),
      .nbits(nbits)
   );

   // a waiting word leaves at a frame boundary, or from idle when enabled
   assign take = buf_full && (busy ? last_end : tx_enable);

   utx_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (take),
      .run      (busy),
      .baud_tick(baud_tick),
      .bit_end  (bit_end)
   );

   utx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (take),
      .frame   (frame),
      .nbits   (nbits),
      .bit_end (bit_end),
      .txd     (txd),
      .busy    (busy),
      .last_end(last_end)
   );

   assign line_out   = txd;
   assign hold_empty = ~buf_full;
   assign tx_busy    = busy;

   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> line_out); // R1

   AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_busy) |-> !line_out); // R2

   AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_busy && !tx_enable) |=> !tx_busy); // R9

   AST_START_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_busy && tx_enable && !hold_empty) |=> (tx_busy && !line_out)); // R9

endmodule

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;

   localparam int CLK_PERIOD = 10;
   localparam int TPB        = 16;
   localparam int DW         = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          baud_tick = 1'b0;
   logic          tx_enable = 1'b0;
   logic          cfg_mp_mode = 1'b0;
   logic          cfg_parity_on = 1'b0;
   logic          cfg_parity_odd = 1'b0;
   logic          cfg_two_stop = 1'b0;
   logic          cfg_wide_data = 1'b1;
   logic          cfg_addr_mark = 1'b0;
   logic          hold_wr = 1'b0;
   logic [DW-1:0] hold_data = '0;
   logic          line_out;
   logic          hold_empty;
   logic          tx_busy;

   int  checks = 0;
   int  errors = 0;
   int  tick_div = 1;
   int  tick_cnt = 0;
   bit  done = 1'b0;

   uart_frame_tx u_uart_frame_tx (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_enable(tx_enable),
      .cfg_mp_mode(cfg_mp_mode), .cfg_parity_on(cfg_parity_on),
      .cfg_parity_odd(cfg_parity_odd), .cfg_two_stop(cfg_two_stop),
      .cfg_wide_data(cfg_wide_data), .cfg_addr_mark(cfg_addr_mark),
      .hold_wr(hold_wr), .hold_data(hold_data),
      .line_out(line_out), .hold_empty(hold_empty), .tx_busy(tx_busy)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      if (tick_cnt + 1 >= tick_div) begin
         tick_cnt  <= 0;
         baud_tick <= 1'b1;
      end else begin
         tick_cnt  <= tick_cnt + 1;
         baud_tick <= 1'b0;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run hung, actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [11:0] expect_frame(input logic [7:0] d, output int n);
      logic [11:0] f;
      bit mp, pe, wide;
      int dl, p;
      logic [7:0] m;
      mp   = cfg_mp_mode;
      pe   = cfg_parity_on && !mp;
      wide = cfg_wide_data || mp;
      dl   = wide ? 8 : 7;
      m    = wide ? 8'hFF : 8'h7F;
      f    = '1;
      f[0] = 1'b0;
      for (int i = 0; i < dl; i++) f[1 + i] = d[i];
      p = 1 + dl;
      if (mp) begin
         f[p] = cfg_addr_mark; p++;
      end else if (pe) begin
         f[p] = (^(d & m)) ^ cfg_parity_odd; p++;
      end
      n = p + 1 + int'(cfg_two_stop);
      return f;
   endfunction

   task automatic write_word(input logic [7:0] d);
      @(negedge clk);
      hold_wr   = 1'b1;
      hold_data = d;
      @(negedge clk);
      hold_wr   = 1'b0;
   endtask

   task automatic wait_taken();
      do @(negedge clk); while (!hold_empty);
   endtask

   // decode one frame at mid-bit points; ends at mid of the following slot
   task automatic run_frame(input logic [7:0] d, input bit chained, input string req);
      logic [11:0] exp, got;
      int n, guard;
      bit busy_mid;
      exp = expect_frame(d, n);
      got = '1;
      if (!chained) begin
         guard = 0;
         do begin
            @(negedge clk);
            guard++;
         end while (line_out && guard < 5000);
         chk(!line_out, req, "start edge", {31'd0, line_out}, 32'd0);
         repeat (TPB/2 * tick_div) @(negedge clk);
      end
      busy_mid = tx_busy;
      for (int i = 0; i < n; i++) begin
         got[i] = line_out;
         repeat (TPB * tick_div) @(negedge clk);
      end
      chk(got == exp, req, "frame bits", {20'd0, got}, {20'd0, exp});
      chk(busy_mid, "R11", "busy mid frame", {31'd0, busy_mid}, 32'd1);
   endtask

   task automatic set_cfg(input bit mp, input bit pe, input bit odd, input bit s2,
                          input bit wide, input bit am);
      cfg_mp_mode = mp; cfg_parity_on = pe; cfg_parity_odd = odd;
      cfg_two_stop = s2; cfg_wide_data = wide; cfg_addr_mark = am;
   endtask

   task automatic check_idle(input string req);
      chk(!tx_busy && line_out && hold_empty, req, "idle after drain",
          {29'd0, tx_busy, line_out, hold_empty}, 32'b011);
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(line_out && hold_empty && !tx_busy, "R1", "reset state",
          {29'd0, line_out, hold_empty, tx_busy}, 32'b110);

      // R9: enable low holds a waiting word
      set_cfg(0, 0, 0, 0, 1, 0);
      tx_enable = 1'b0;
      write_word(8'hA5);
      chk(!hold_empty, "R7", "slot full after write", {31'd0, hold_empty}, 32'd0);
      repeat (200) @(negedge clk);
      chk(line_out && !tx_busy, "R9", "no start while disabled",
          {30'd0, line_out, tx_busy}, 32'b10);
      tx_enable = 1'b1;
      run_frame(8'hA5, 0, "R2");
      check_idle("R11");

      // R3: seven bits, bit 7 ignored
      set_cfg(0, 0, 0, 0, 0, 0);
      fork write_word(8'hC3); run_frame(8'hC3, 0, "R3"); join

      // R4: even and odd parity
      set_cfg(0, 1, 0, 0, 1, 0);
      fork write_word(8'h07); run_frame(8'h07, 0, "R4"); join
      set_cfg(0, 1, 1, 0, 1, 0);
      fork write_word(8'h07); run_frame(8'h07, 0, "R4"); join
      set_cfg(0, 1, 1, 0, 0, 0);
      fork write_word(8'hF0); run_frame(8'hF0, 0, "R4"); join

      // R5 + R8: two stop bits, then gapless chained frame
      set_cfg(0, 0, 0, 1, 1, 0);
      tick_div = 3;
      fork
         begin write_word(8'h3C); wait_taken(); write_word(8'hE1); end
         begin run_frame(8'h3C, 0, "R5"); run_frame(8'hE1, 1, "R8"); end
      join
      check_idle("R5");
      tick_div = 1;

      // R6: multiprocessor, parity and short width requested but ignored
      set_cfg(1, 1, 1, 0, 0, 1);
      fork write_word(8'h81); run_frame(8'h81, 0, "R6"); join
      set_cfg(1, 1, 0, 1, 0, 0);
      fork write_word(8'hFE); run_frame(8'hFE, 0, "R6"); join

      // R7: third write while slot full is dropped
      set_cfg(0, 0, 0, 0, 1, 0);
      fork
         begin write_word(8'h11); wait_taken(); write_word(8'h22); write_word(8'h33); end
         begin run_frame(8'h11, 0, "R7"); run_frame(8'h22, 1, "R7"); end
      join
      check_idle("R7");
      repeat (20 * TPB) @(negedge clk);
      chk(line_out && !tx_busy, "R7", "dropped word never sent",
          {30'd0, line_out, tx_busy}, 32'b10);

      // R10: enable cleared mid-frame, buffered word still drains
      fork
         begin
            write_word(8'h5A); wait_taken(); write_word(8'h96);
            repeat (30) @(negedge clk);
            tx_enable = 1'b0;
         end
         begin run_frame(8'h5A, 0, "R10"); run_frame(8'h96, 1, "R10"); end
      join
      check_idle("R10");
      write_word(8'h44);
      repeat (100) @(negedge clk);
      chk(!tx_busy && line_out, "R10", "stays stopped after drain",
          {30'd0, tx_busy, line_out}, 32'b01);
      tx_enable = 1'b1;
      run_frame(8'h44, 0, "R9");

      // random frames
      for (int k = 0; k < 40; k++) begin
         logic [7:0] a, b;
         bit two;
         set_cfg($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                 $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
         tick_div = $urandom_range(1, 3);
         a = 8'($urandom);
         b = 8'($urandom);
         two = $urandom_range(0, 1);
         if (two) begin
            fork
               begin write_word(a); wait_taken(); write_word(b); end
               begin run_frame(a, 0, "R2"); run_frame(b, 1, "R8"); end
            join
         end else begin
            fork write_word(a); run_frame(a, 0, "R2"); join
         end
         check_idle("R11");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
      $finish;
   end

endmodule